// File: doc/BRIEF.md
# Microprogram Address Sequencer

This block produces the control-memory address for a microprogrammed control unit. It keeps a registered control address and a single-entry return-address register. On every clock edge it loads the control address from one of four sources: the current address plus one, the address field of the running microinstruction, a routine start address derived from the instruction opcode, or the saved return address.

The condition-select and branch-type fields of the current microinstruction pick the source, together with the indirect bit of the instruction word and two accumulator status flags. The surrounding control unit reads the microinstruction at `ctrl_addr` from its control memory and feeds the condition, branch and address fields back into this block in the same cycle. Decoding of the microoperation fields and the datapath sit outside this block.

The instruction word has a fixed layout that the block decodes. Bit 15 is the indirect flag. Bits 14 to 11 hold the opcode. The low bits carry the memory address, which this block does not use.

Top module: `micro_addr_seq`

## Requirements
- R1: While `rst` is high at a rising edge, `ctrl_addr` becomes FETCH_ADDR (default 64) and the return register becomes 0. The cleared return register is seen through a later return.
- R2: A jump (`br_type`=00) whose selected condition is true loads `ctrl_addr` with `br_addr` at the next edge.
- R3: A jump whose selected condition is false loads `ctrl_addr` with `ctrl_addr`+1.
- R4: `cond_sel` chooses the condition as follows: 00 is always true, 01 is `instr_word[15]`, 10 is `acc_sign`, and 11 is `acc_zero`.
- R5: A map (`br_type`=11) loads `ctrl_addr` with {0, `instr_word[14:11]`, 00}, which is the opcode times 4. It does this whatever the condition.
- R6: A call (`br_type`=01) whose condition is true loads `ctrl_addr` with `br_addr`. At the same edge it stores `ctrl_addr`+1 in the return register.
- R7: A call whose condition is false increments `ctrl_addr` and leaves the return register unchanged.
- R8: A return (`br_type`=10) loads `ctrl_addr` from the return register, whatever the condition.
- R9: The return register holds one level only. A second taken call overwrites the first return address.
- R10: Incrementing wraps modulo 128, so address 127 is followed by 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cond_sel | input | 2 | Condition-select field of the current microinstruction |
| br_type | input | 2 | Branch-type field of the current microinstruction |
| br_addr | input | 7 | Address field of the current microinstruction |
| instr_word | input | 16 | Instruction register: indirect flag, opcode, memory address |
| acc_sign | input | 1 | Accumulator sign status |
| acc_zero | input | 1 | Accumulator zero status |
| ctrl_addr | output | 7 | Registered control-memory address |

## Verification
The assertions assume that the microinstruction fields and status inputs are stable and known at each rising edge. They also assume that those fields describe the word addressed by the current `ctrl_addr`. The bench meets this by changing inputs only on falling edges, and it never leaves a field undriven after reset. Its stimulus runs through directed sequences for each condition code and branch type, covering nested calls, wrap-around and return after reset. After that it applies a long stream of pseudo-random field combinations, all of which are legal encodings because every 2-bit value is defined.

// File: rtl/mseq_pkg.sv
package mseq_pkg;
  typedef enum logic [1:0] {
    CD_ALWAYS   = 2'b00,
    CD_INDIRECT = 2'b01,
    CD_SIGN     = 2'b10,
    CD_ZERO     = 2'b11
  } cond_e;

  typedef enum logic [1:0] {
    BR_JUMP = 2'b00,
    BR_CALL = 2'b01,
    BR_RET  = 2'b10,
    BR_MAP  = 2'b11
  } branch_e;
endpackage

// File: rtl/mseq_cond_sel.sv
module mseq_cond_sel
  import mseq_pkg::*;
(
  input  logic [1:0] cond_sel,
  input  logic       ind_bit,
  input  logic       sign_bit,
  input  logic       zero_bit,
  output logic       cond_true
);
  always_comb begin
    case (cond_e'(cond_sel))
      CD_ALWAYS:   cond_true = 1'b1;
      CD_INDIRECT: cond_true = ind_bit;
      CD_SIGN:     cond_true = sign_bit;
      default:     cond_true = zero_bit;
    endcase
  end
endmodule

// File: rtl/mseq_next_addr.sv
module mseq_next_addr
  import mseq_pkg::*;
#(
  parameter int AW      = 7,
  parameter int OPW     = 4,
  parameter int MAP_LSB = 2
) (
  input  logic [AW-1:0]  car,
  input  logic [AW-1:0]  sbr,
  input  logic [1:0]     br_type,
  input  logic           cond_true,
  input  logic [AW-1:0]  br_addr,
  input  logic [OPW-1:0] opcode,
  output logic [AW-1:0]  nxt,
  output logic           link_we,
  output logic [AW-1:0]  link_val
);
  localparam int MAPW = OPW + MAP_LSB;

  logic [AW-1:0] inc_addr;
  logic [AW-1:0] map_addr;

  assign inc_addr = car + AW'(1);
  assign link_val = inc_addr;

  generate
    if (AW > MAPW) begin : g_pad
      assign map_addr = {{(AW-MAPW){1'b0}}, opcode, {MAP_LSB{1'b0}}};
    end else begin : g_exact
      assign map_addr = {opcode, {MAP_LSB{1'b0}}};
    end
  endgenerate

  always_comb begin
    nxt     = inc_addr;
    link_we = 1'b0;
    case (branch_e'(br_type))
      BR_JUMP: if (cond_true) nxt = br_addr;
      BR_CALL: if (cond_true) begin
        nxt     = br_addr;
        link_we = 1'b1;
      end
      BR_RET:  nxt = sbr;
      default: nxt = map_addr;
    endcase
  end
endmodule

// File: rtl/mseq_link_reg.sv
module mseq_link_reg #(
  parameter int AW = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] din,
  output logic [AW-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (we) q <= din;
  end
endmodule

// File: rtl/micro_addr_seq.sv
module micro_addr_seq
  import mseq_pkg::*;
#(
  parameter int AW         = 7,
  parameter int IW         = 16,
  parameter int OPW        = 4,
  parameter int MAP_LSB    = 2,
  parameter int FETCH_ADDR = 64
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    cond_sel,
  input  logic [1:0]    br_type,
  input  logic [AW-1:0] br_addr,
  input  logic [IW-1:0] instr_word,
  input  logic          acc_sign,
  input  logic          acc_zero,
  output logic [AW-1:0] ctrl_addr
);
  localparam int IND_BIT = IW - 1;
  localparam int OP_HI   = IW - 2;
  localparam int OP_LO   = IW - 1 - OPW;

  logic           cond_true;
  logic [AW-1:0]  nxt;
  logic           link_we;
  logic [AW-1:0]  link_val;
  logic [AW-1:0]  sbr;
  logic [OPW-1:0] opcode;
  logic           unused_addr_bits;

  assign opcode           = instr_word[OP_HI:OP_LO];
  assign unused_addr_bits = ^instr_word[OP_LO-1:0];

  mseq_cond_sel u_cond (
    .cond_sel (cond_sel),
    .ind_bit  (instr_word[IND_BIT]),
    .sign_bit (acc_sign),
    .zero_bit (acc_zero),
    .cond_true(cond_true)
  );

  mseq_next_addr #(.AW(AW), .OPW(OPW), .MAP_LSB(MAP_LSB)) u_next (
    .car      (ctrl_addr),
    .sbr      (sbr),
    .br_type  (br_type),
    .cond_true(cond_true),
    .br_addr  (br_addr),
    .opcode   (opcode),
    .nxt      (nxt),
    .link_we  (link_we),
    .link_val (link_val)
  );

  mseq_link_reg #(.AW(AW)) u_link (
    .clk(clk),
    .rst(rst),
    .we (link_we),
    .din(link_val),
    .q  (sbr)
  );

  always_ff @(posedge clk) begin
    if (rst) ctrl_addr <= AW'(FETCH_ADDR);
    else     ctrl_addr <= nxt;
  end

  // R1: the cycle after reset holds the fetch address
  p_reset_fetch_r1: assert property (@(posedge clk)
    $past(rst) |-> ctrl_addr == AW'(FETCH_ADDR));

  // R2: a taken jump lands on the address field
  p_jump_taken_r2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(br_type) == BR_JUMP && $past(cond_true))
      |-> ctrl_addr == $past(br_addr));

  // R3: a skipped jump steps by one
  p_jump_skip_r3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(br_type) == BR_JUMP && !$past(cond_true))
      |-> ctrl_addr == $past(ctrl_addr) + AW'(1));

  // R5: mapping forms the routine start from the opcode
  p_map_addr_r5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(br_type) == BR_MAP)
      |-> (ctrl_addr[MAP_LSB-1:0] == '0 &&
           ctrl_addr[MAP_LSB +: OPW] == $past(instr_word[OP_HI:OP_LO])));

  // R6: a taken call records the following address
  p_call_link_r6: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(br_type) == BR_CALL && $past(cond_true))
      |-> (sbr == $past(ctrl_addr) + AW'(1) && ctrl_addr == $past(br_addr)));

  // R7: a skipped call keeps the return address
  p_call_skip_r7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(br_type) == BR_CALL && !$past(cond_true))
      |-> $stable(sbr));

  // R8: a return restores the saved address
  p_return_r8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(br_type) == BR_RET)
      |-> ctrl_addr == $past(sbr));
endmodule

// File: tb/micro_addr_seq_tb.sv
module micro_addr_seq_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  cond_sel = 2'b00;
  logic [1:0]  br_type = 2'b00;
  logic [6:0]  br_addr = 7'd0;
  logic [15:0] instr_word = 16'd0;
  logic        acc_sign = 1'b0;
  logic        acc_zero = 1'b0;
  logic [6:0]  ctrl_addr;

  int total = 0;
  int bad = 0;
  int car_m = 0;
  int sbr_m = 0;
  bit done = 1'b0;
  int unsigned lfsr = 32'h1234_5679;

  always #4 clk = ~clk;

  micro_addr_seq u_dut (
    .clk(clk), .rst(rst), .cond_sel(cond_sel), .br_type(br_type),
    .br_addr(br_addr), .instr_word(instr_word), .acc_sign(acc_sign),
    .acc_zero(acc_zero), .ctrl_addr(ctrl_addr)
  );

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (2) @(posedge clk);
    car_m = 64;
    sbr_m = 0;
    @(negedge clk);
    rst = 1'b0;
    check("R1 reset address", ctrl_addr, 64);
  endtask

  task automatic step(input logic [1:0] cd, input logic [1:0] br, input int ad,
                      input logic [15:0] iw, input logic s, input logic z,
                      input string tag);
    bit taken;
    cond_sel = cd; br_type = br; br_addr = ad[6:0];
    instr_word = iw; acc_sign = s; acc_zero = z;
    @(posedge clk);
    case (cd)
      2'd0: taken = 1'b1;
      2'd1: taken = iw[15];
      2'd2: taken = s;
      default: taken = z;
    endcase
    case (br)
      2'd0: car_m = taken ? ad : (car_m + 1) % 128;
      2'd1: if (taken) begin sbr_m = (car_m + 1) % 128; car_m = ad; end
            else car_m = (car_m + 1) % 128;
      2'd2: car_m = sbr_m;
      default: car_m = int'(iw[14:11]) * 4;
    endcase
    @(negedge clk);
    check(tag, ctrl_addr, car_m);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    do_reset();
    step(2'd0, 2'd2, 5, 16'h0, 0, 0, "R1 cleared return register");
    check("R1 return after reset", ctrl_addr, 0);
    do_reset();
    step(2'd0, 2'd0, 10, 16'h0, 0, 0, "R2 jump always");
    check("R2 jump target", ctrl_addr, 10);
    step(2'd1, 2'd0, 50, 16'h0000, 0, 0, "R3/R4 indirect false");
    check("R3 increment", ctrl_addr, 11);
    step(2'd1, 2'd0, 20, 16'h8000, 0, 0, "R4 indirect true");
    step(2'd2, 2'd0, 30, 16'h0, 1, 0, "R4 sign true");
    step(2'd2, 2'd0, 90, 16'h0, 0, 1, "R4 sign false");
    check("R4 sign false increments", ctrl_addr, 31);
    step(2'd3, 2'd0, 40, 16'h0, 0, 1, "R4 zero true");
    step(2'd3, 2'd0, 70, 16'h0, 1, 0, "R4 zero false");
    step(2'd2, 2'd3, 3, 16'h7800, 0, 0, "R5 map opcode 15");
    check("R5 map value", ctrl_addr, 60);
    step(2'd0, 2'd3, 3, 16'h2FFF, 0, 0, "R5 map opcode 5");
    check("R5 map value", ctrl_addr, 20);
    step(2'd0, 2'd1, 100, 16'h0, 0, 0, "R6 call taken");
    step(2'd2, 2'd1, 9, 16'h0, 0, 0, "R7 call skipped");
    step(2'd0, 2'd0, 110, 16'h0, 0, 0, "R2 jump away");
    step(2'd2, 2'd2, 0, 16'h0, 0, 0, "R8 return cond false");
    check("R6/R7 return address", ctrl_addr, 21);
    step(2'd0, 2'd1, 80, 16'h0, 0, 0, "R6 outer call");
    step(2'd3, 2'd1, 90, 16'h0, 0, 1, "R9 nested call");
    step(2'd0, 2'd2, 0, 16'h0, 0, 0, "R9 return after nesting");
    check("R9 nested overwrite", ctrl_addr, 81);
    step(2'd0, 2'd0, 127, 16'h0, 0, 0, "R2 jump to top");
    step(2'd2, 2'd0, 5, 16'h0, 0, 0, "R10 wrap");
    check("R10 wrap to zero", ctrl_addr, 0);
    for (int i = 0; i < 400; i++) begin
      logic [1:0] cd, br;
      string tag;
      lfsr ^= lfsr << 13; lfsr ^= lfsr >> 17; lfsr ^= lfsr << 5;
      cd = lfsr[1:0]; br = lfsr[3:2];
      case (br)
        2'd0: tag = "R2/R3 random jump";
        2'd1: tag = "R6/R7 random call";
        2'd2: tag = "R8 random return";
        default: tag = "R5 random map";
      endcase
      step(cd, br, int'(lfsr[10:4]), lfsr[26:11], lfsr[27], lfsr[28], tag);
    end
    do_reset();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule